// File: doc/BRIEF.md
# Reloading 16-bit Interval Timer

This block is a down-counter with its own reload latch, controlled through four byte-wide registers. A host writes the period in two bytes; writing the upper byte through the start register copies the whole latch into the counter and begins a new count. The counter steps down once for each cycle in which the `tick` clock-enable is high. When a step brings the count to zero, the block raises `irq_flag`, which goes on to a separate interrupt-combining unit.

Two modes are chosen by one bit of an auxiliary control byte. In continuous mode, the counter passes through zero to all-ones and then reloads from the latch. The flag is raised once per period of latch + 2 ticks. In one-shot mode the counter wraps freely and never reloads, and the flag is raised only once for each start. Reading the low count byte clears the flag. Writing the upper latch byte also clears it.

Top module: `reload_timer16`

## Requirements
- R1: After reset the latch and the counter hold 0xFFFF and `irq_flag` is low.
- R2: Register select `addr` decodes as 0 = counter low, 1 = counter high (start), 2 = latch low, 3 = latch high. A write to address 0 or 2 replaces only the low latch byte and leaves the counter unchanged.
- R3: A write to address 1 replaces the high latch byte, loads the full 16-bit latch (new high byte, current low byte) into the counter and clears `irq_flag`.
- R4: A write to address 3 replaces the high latch byte and clears `irq_flag` without touching the counter.
- R5: The counter decreases by one on each edge where `tick` is high and holds its value otherwise.
- R6: In continuous mode, a tick taken at count 0xFFFF loads the latch into the counter, so successive flag events are latch + 2 ticks apart.
- R7: `irq_flag` is set by the tick that brings the counter to zero.
- R8: `rdata` shows the byte selected by `addr` at all times. A read strobe at address 0 clears `irq_flag`. A read at address 1 leaves the flag unchanged.
- R9: Addresses 2 and 3 read back the low and high latch bytes.
- R10: In one-shot mode the counter runs from 0 to 0xFFFF and then 0xFFFE with no reload. The flag is raised only the first time zero is reached after each write to address 1.
- R11: Bit 6 of `aux_ctrl` selects the mode (1 = continuous, 0 = one-shot). Its other bits have no effect.
- R12: When a tick brings the count to zero, the flag is set even if a low-count read or a latch-high write falls in the same cycle. A write to address 1 in the same cycle as a tick loads the latch and skips the decrement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one step per high cycle |
| aux_ctrl | input | 8 | Auxiliary control byte; bit 6 selects continuous mode |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe (side effects only) |
| rdata | output | 8 | Selected register byte |
| irq_flag | output | 1 | Timer expiry flag |

## Verification
The counting path and the register path meet in one cycle whenever a tick lands together with a host access. The bench places the tick that brings the count to zero in the same cycle as a low-count read, and later in the same cycle as a latch-high write. In both cases it expects the flag to be set afterwards, while the read still returns the pre-step count. It also issues a start write together with a tick and checks that the counter holds the freshly loaded latch value, not one less, and that the flag is clear.

// File: rtl/rt16_pkg.sv
package rt16_pkg;

    typedef enum logic [1:0] {
        SEL_CNT_LO = 2'd0,
        SEL_CNT_HI = 2'd1,
        SEL_LAT_LO = 2'd2,
        SEL_LAT_HI = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/rt16_latch.sv
module rt16_latch #(
    parameter int CNT_W = 16,
    localparam int HALF = CNT_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [HALF-1:0]  wdata,
    output logic [CNT_W-1:0] latch_q
);

    typedef struct packed {
        logic [HALF-1:0] hi;
        logic [HALF-1:0] lo;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lo) st_d.lo = wdata;
        if (wr_hi) st_d.hi = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign latch_q = st_q;

    p_lo_keep_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo && !wr_hi |=> latch_q[CNT_W-1:HALF] == $past(latch_q[CNT_W-1:HALF]));

endmodule

// File: rtl/rt16_counter.sv
module rt16_counter #(
    parameter int CNT_W = 16,
    localparam int HALF = CNT_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [HALF-1:0]  load_hi,
    input  logic             cont,
    input  logic [CNT_W-1:0] latch_q,
    output logic [CNT_W-1:0] count_q,
    output logic             reach_zero
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = {load_hi, latch_q[HALF-1:0]};
        end else if (tick) begin
            if (cont && st_q.cnt == ALL_ONES) st_d.cnt = latch_q;
            else                              st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    assign reach_zero = tick && !load && (st_d.cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.cnt <= ALL_ONES;
        else        st_q     <= st_d;
    end

    assign count_q = st_q.cnt;

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !load |=> $stable(count_q));

    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !load && count_q != ALL_ONES |=> count_q == $past(count_q) - 1'b1);

    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !load && cont && count_q == ALL_ONES |=> count_q == $past(latch_q));

    p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !load && !cont && count_q == '0 |=> count_q == ALL_ONES);

endmodule

// File: rtl/rt16_flag.sv
module rt16_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic reach_zero,
    input  logic cont,
    input  logic arm,
    input  logic clr,
    output logic flag_q
);

    typedef struct packed {
        logic flag;
        logic armed;
    } flag_t;

    flag_t st_d, st_q;
    logic  set_ev;

    always_comb begin
        st_d   = st_q;
        set_ev = reach_zero && (cont || st_q.armed);
        if (arm) begin
            st_d.flag  = 1'b0;
            st_d.armed = 1'b1;
        end else if (set_ev) begin
            st_d.flag = 1'b1;
            if (!cont) st_d.armed = 1'b0;
        end else if (clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_q = st_q.flag;

    p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reach_zero && cont && !arm |=> flag_q);

    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev && clr |=> flag_q);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !reach_zero && !arm |=> !flag_q);

    p_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cont && reach_zero && !arm |=> !st_q.armed);

endmodule

// File: rtl/rt16_rdmux.sv
module rt16_rdmux
    import rt16_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int HALF = CNT_W / 2
) (
    input  reg_sel_e         sel,
    input  logic [CNT_W-1:0] count_q,
    input  logic [CNT_W-1:0] latch_q,
    output logic [HALF-1:0]  rdata
);

    always_comb begin
        unique case (sel)
            SEL_CNT_LO: rdata = count_q[HALF-1:0];
            SEL_CNT_HI: rdata = count_q[CNT_W-1:HALF];
            SEL_LAT_LO: rdata = latch_q[HALF-1:0];
            default:    rdata = latch_q[CNT_W-1:HALF];
        endcase
    end

endmodule

// File: rtl/reload_timer16.sv
module reload_timer16
    import rt16_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int ACR_W    = 8,
    parameter int MODE_BIT = 6,
    localparam int HALF    = CNT_W / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [ACR_W-1:0] aux_ctrl,
    input  logic [1:0]      addr,
    input  logic            wr_en,
    input  logic [HALF-1:0] wdata,
    input  logic            rd_en,
    output logic [HALF-1:0] rdata,
    output logic            irq_flag
);

    reg_sel_e         sel;
    logic             wr_cnt_lo, wr_cnt_hi, wr_lat_lo, wr_lat_hi, rd_cnt_lo;
    logic             cont;
    logic [CNT_W-1:0] latch_q, count_q;
    logic             reach_zero;
    logic             unused_aux;

    assign sel        = reg_sel_e'(addr);
    assign wr_cnt_lo  = wr_en && sel == SEL_CNT_LO;
    assign wr_cnt_hi  = wr_en && sel == SEL_CNT_HI;
    assign wr_lat_lo  = wr_en && sel == SEL_LAT_LO;
    assign wr_lat_hi  = wr_en && sel == SEL_LAT_HI;
    assign rd_cnt_lo  = rd_en && sel == SEL_CNT_LO;
    assign cont       = aux_ctrl[MODE_BIT];
    assign unused_aux = ^aux_ctrl;

    rt16_latch #(.CNT_W(CNT_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_lo  (wr_cnt_lo || wr_lat_lo),
        .wr_hi  (wr_cnt_hi || wr_lat_hi),
        .wdata  (wdata),
        .latch_q(latch_q)
    );

    rt16_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load      (wr_cnt_hi),
        .load_hi   (wdata),
        .cont      (cont),
        .latch_q   (latch_q),
        .count_q   (count_q),
        .reach_zero(reach_zero)
    );

    rt16_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .reach_zero(reach_zero),
        .cont      (cont),
        .arm       (wr_cnt_hi),
        .clr       (rd_cnt_lo || wr_lat_hi),
        .flag_q    (irq_flag)
    );

    rt16_rdmux #(.CNT_W(CNT_W)) u_rdmux (
        .sel    (sel),
        .count_q(count_q),
        .latch_q(latch_q),
        .rdata  (rdata)
    );

    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_hi |=> count_q == latch_q && !irq_flag);

    p_lathi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lat_hi && !tick |=> $stable(count_q) && !irq_flag);

    p_lowr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt_lo || wr_lat_lo) && !tick |=> $stable(count_q));

    p_collide_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_hi && tick |=> count_q == latch_q);

endmodule

// File: tb/reload_timer16_test.sv
module reload_timer16_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] aux_ctrl = 8'h00;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       irq_flag;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    reload_timer16 uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .aux_ctrl(aux_ctrl),
        .addr(addr), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
        .rdata(rdata), .irq_flag(irq_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic count_is(input string req, input int exp);
        logic [7:0] lo, hi;
        peek(2'd0, lo);
        peek(2'd1, hi);
        check(req, {hi, lo}, exp);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R1 flag", irq_flag, 0);
        count_is("R1 count", 16'hFFFF);
        peek(2'd2, v); check("R1 latch lo", v, 8'hFF);
        peek(2'd3, v); check("R1 latch hi", v, 8'hFF);
    endtask

    task automatic t_latch_writes;
        logic [7:0] v;
        wr(2'd0, 8'h34);
        peek(2'd2, v); check("R2 cnt-lo write to latch lo", v, 8'h34);
        count_is("R2 count untouched", 16'hFFFF);
        wr(2'd2, 8'h12);
        peek(2'd2, v); check("R9 latch lo read", v, 8'h12);
        wr(2'd3, 8'hAB);
        peek(2'd3, v); check("R9 latch hi read", v, 8'hAB);
        count_is("R4 count untouched", 16'hFFFF);
    endtask

    task automatic t_continuous;
        logic [7:0] v;
        aux_ctrl = 8'h40;
        wr(2'd2, 8'h05);
        wr(2'd1, 8'h00);
        count_is("R3 start loads latch", 16'h0005);
        check("R3 flag clear", irq_flag, 0);
        ticks(3);
        count_is("R5 three ticks", 16'h0002);
        repeat (2) @(negedge clk);
        count_is("R5 hold without tick", 16'h0002);
        ticks(2);
        count_is("R7 zero", 16'h0000);
        check("R7 flag at zero", irq_flag, 1);
        ticks(1);
        count_is("R6 all ones", 16'hFFFF);
        ticks(1);
        count_is("R6 reload", 16'h0005);
        rd(2'd1, v);
        check("R8 high read data", v, 8'h00);
        check("R8 high read keeps flag", irq_flag, 1);
        rd(2'd0, v);
        check("R8 low read data", v, 8'h05);
        check("R8 low read clears flag", irq_flag, 0);
        ticks(4);
        check("R6 no flag before period", irq_flag, 0);
        ticks(1);
        check("R6 flag after latch+2", irq_flag, 1);
        rd(2'd0, v);
    endtask

    task automatic t_one_shot;
        logic [7:0] v;
        aux_ctrl = 8'hBF;
        wr(2'd2, 8'h03);
        wr(2'd1, 8'h00);
        ticks(3);
        check("R10 first flag", irq_flag, 1);
        rd(2'd0, v);
        check("R8 clear in one-shot", irq_flag, 0);
        ticks(2);
        count_is("R10 wraps without reload", 16'hFFFE);
        check("R11 other aux bits ignored", irq_flag, 0);
        ticks(16'hFFFE);
        count_is("R10 second zero", 16'h0000);
        check("R10 no second flag", irq_flag, 0);
        wr(2'd1, 8'h00);
        count_is("R3 restart", 16'h0003);
        ticks(3);
        check("R10 rearmed flag", irq_flag, 1);
        rd(2'd0, v);
    endtask

    task automatic t_collisions;
        logic [7:0] v;
        aux_ctrl = 8'h40;
        wr(2'd2, 8'h02);
        wr(2'd1, 8'h00);
        ticks(1);
        addr = 2'd0; rd_en = 1'b1; tick = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0; tick = 1'b0;
        check("R12 read data pre-step", v, 8'h01);
        check("R12 set beats read clear", irq_flag, 1);
        count_is("R12 count zero", 16'h0000);
        rd(2'd0, v);
        check("R8 cleared", irq_flag, 0);
        ticks(3);
        count_is("R6 one after reload", 16'h0001);
        tick = 1'b1;
        wr(2'd3, 8'h00);
        tick = 1'b0;
        check("R12 set beats latch-hi clear", irq_flag, 1);
        count_is("R12 count stepped", 16'h0000);
        tick = 1'b1;
        wr(2'd1, 8'h00);
        tick = 1'b0;
        count_is("R12 start beats tick", 16'h0002);
        check("R12 start clears flag", irq_flag, 0);
        ticks(2);
        check("R7 flag after restart", irq_flag, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch_writes();
        t_continuous();
        t_one_shot();
        t_collisions();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule